// File: doc/BRIEF.md
# SMBus IPMI Request Assembler

This block sits behind an SMBus target and receives the block-write transactions a host uses to send IPMI requests. Each transaction arrives as a byte stream: a command byte, a length byte and up to 32 payload bytes, with the final byte flagged. The block checks each transaction and either rejects it with a one-cycle pulse or builds a request in a 255-byte message store. A request may arrive in one transaction or in a chain of start, middle and end pieces.

When a request is complete, the block streams it to the BMC command logic over a valid/ready byte port. The last byte is flagged, and every byte of a message carries the same 8-bit tag. The tag goes up by one for each message sent. The system interface capabilities query is not forwarded. The block answers it itself and places the answer in a small response store, which the read side fetches by byte address.

Top module: `sbreq_assembler`

## Requirements
- R1: A write is rejected (one-cycle `wr_reject` pulse, no change to the stored message) unless it carries a length byte equal to its payload byte count and no greater than 32; a write made of the command byte alone is rejected.
- R2: Command 0x02 (single-part) and 0x06 (multi-part start) need at least 2 payload bytes, otherwise they are rejected. An accepted one replaces the stored message with its payload.
- R3: Command 0x07 (middle) and 0x08 (end) are rejected while no message is stored, including right after reset. Otherwise their payload is appended behind the stored bytes.
- R4: An append that would make the message longer than 255 bytes empties the store and is rejected; a message of exactly 255 bytes is accepted and forwarded whole.
- R5: A message is complete after an accepted 0x02, an accepted 0x08, or an accepted 0x07 with fewer than 32 payload bytes (zero included); 0x06 and a 32-byte 0x07 leave it open.
- R6: A complete message is sent on `req_data` in arrival order, with `req_last` on its final byte. Valid, data, last and tag hold steady while `req_ready` is low. The tag starts at 0 after reset and rises by one (mod 256) per forwarded message, and the store is empty afterwards.
- R7: A complete message starting 0x18, 0x57 is not forwarded. The response store then holds 0x1C, 0x57 and a completion code, followed on success by 0x00, 0x80, 0xFF, 0xFF (7 bytes in all). Reads at or beyond `rsp_len` return 0x00.
- R8: The answer is 3 bytes with code 0xC7 when the query had fewer than 3 bytes. It is 3 bytes with code 0xCC when the low nibble of its third byte is nonzero. Otherwise the code is 0x00.
- R9: A write that ends while a message is being copied or forwarded is rejected and does not disturb that message.
- R10: An accepted 0x02 or 0x06 empties the response store (`rsp_len` = 0).
- R11: Any command code other than 0x02, 0x06, 0x07 or 0x08 is rejected.
- R12: After reset `req_valid` is low and `rsp_len` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write byte present |
| wr_data | input | 8 | Write byte: command, then length, then payload |
| wr_last | input | 1 | Marks the final byte of a write |
| wr_reject | output | 1 | One-cycle pulse per discarded write |
| req_valid | output | 1 | Forwarded byte valid |
| req_ready | input | 1 | Downstream accepts the byte |
| req_data | output | 8 | Forwarded message byte |
| req_last | output | 1 | Final byte of the forwarded message |
| req_tag | output | 8 | Sequence tag of the forwarded message |
| rsp_len | output | 3 | Bytes held in the response store (0, 3 or 7) |
| rsp_addr | input | 3 | Response byte address |
| rsp_data | output | 8 | Response byte at `rsp_addr` |

## Verification
The hardest situation to reach from the ports is a new write that finishes while a message is stalled on the output or is still being copied. Normal traffic leaves the block idle long before the next write. The bench holds `req_ready` low for a chosen message, sends a second write into the stall and checks the stalled byte and the later message contents. The 255-byte boundary and the overflow discard need long chains of full-size middle pieces. These chains are driven directly, and seeded random traffic mixes valid, mislengthed and unknown writes with capability queries.

// File: rtl/sbreq_pkg.sv
package sbreq_pkg;
  localparam logic [7:0] CMD_SINGLE   = 8'h02;
  localparam logic [7:0] CMD_START    = 8'h06;
  localparam logic [7:0] CMD_MIDDLE   = 8'h07;
  localparam logic [7:0] CMD_END      = 8'h08;

  localparam logic [7:0] CAPQ_NETFN   = 8'h18;
  localparam logic [7:0] CAPR_NETFN   = 8'h1C;
  localparam logic [7:0] CAP_OPCODE   = 8'h57;

  localparam logic [7:0] CC_GOOD      = 8'h00;
  localparam logic [7:0] CC_BAD_LEN   = 8'hC7;
  localparam logic [7:0] CC_BAD_FIELD = 8'hCC;

  typedef enum logic [1:0] {PH_CMD, PH_LEN, PH_PAY} rx_phase_e;
  typedef enum logic [1:0] {ST_IDLE, ST_COPY, ST_FWD} asm_state_e;
endpackage

// File: rtl/sbreq_chunk_rx.sv
module sbreq_chunk_rx
  import sbreq_pkg::*;
#(
  parameter int CHUNK_MAX = 32
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 in_valid,
  input  logic [7:0]                           in_data,
  input  logic                                 in_last,
  input  logic                                 hold,
  input  logic [$clog2(CHUNK_MAX)-1:0]         stage_idx,
  output logic [7:0]                           stage_byte,
  output logic                                 chk_valid,
  output logic [7:0]                           chk_cmd,
  output logic [$clog2(CHUNK_MAX+2)-1:0]       chk_len,
  output logic                                 chk_ok,
  output logic                                 chk_dropped
);
  localparam int CW = $clog2(CHUNK_MAX + 2);
  localparam int IW = $clog2(CHUNK_MAX);

  rx_phase_e       phase_q, phase_d;
  logic [7:0]      cmd_q, cmd_d;
  logic [7:0]      lenb_q, lenb_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic            drop_q, drop_d;
  logic            done_d, ok_d;
  logic            stage_we;
  logic [7:0]      stage_q [CHUNK_MAX];

  always_comb begin
    phase_d  = phase_q;
    cmd_d    = cmd_q;
    lenb_d   = lenb_q;
    cnt_d    = cnt_q;
    drop_d   = drop_q;
    done_d   = 1'b0;
    ok_d     = 1'b0;
    stage_we = 1'b0;
    if (in_valid) begin
      unique case (phase_q)
        PH_CMD: begin
          cmd_d  = in_data;
          lenb_d = 8'd0;
          cnt_d  = '0;
          drop_d = hold;
        end
        PH_LEN: begin
          lenb_d = in_data;
          drop_d = drop_q | hold;
        end
        default: begin
          if (cnt_q <= CW'(CHUNK_MAX)) cnt_d = cnt_q + 1'b1;
          stage_we = !(drop_q || hold) && (cnt_q < CW'(CHUNK_MAX));
          drop_d   = drop_q | hold;
        end
      endcase
      if (in_last) begin
        phase_d = PH_CMD;
        done_d  = 1'b1;
        ok_d    = (phase_q != PH_CMD) && (lenb_d == 8'(cnt_d)) &&
                  (lenb_d <= 8'(CHUNK_MAX));
      end else begin
        phase_d = (phase_q == PH_CMD) ? PH_LEN : PH_PAY;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q     <= PH_CMD;
      cmd_q       <= 8'd0;
      lenb_q      <= 8'd0;
      cnt_q       <= '0;
      drop_q      <= 1'b0;
      chk_valid   <= 1'b0;
      chk_cmd     <= 8'd0;
      chk_len     <= '0;
      chk_ok      <= 1'b0;
      chk_dropped <= 1'b0;
    end else begin
      phase_q     <= phase_d;
      cmd_q       <= cmd_d;
      lenb_q      <= lenb_d;
      cnt_q       <= cnt_d;
      drop_q      <= drop_d;
      chk_valid   <= done_d;
      if (done_d) begin
        chk_cmd     <= cmd_d;
        chk_len     <= cnt_d;
        chk_ok      <= ok_d;
        chk_dropped <= drop_d;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (stage_we) stage_q[cnt_q[IW-1:0]] <= in_data;
  end

  assign stage_byte = stage_q[stage_idx];

  assert_len_cap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid && chk_ok |-> chk_len <= CW'(CHUNK_MAX));
endmodule

// File: rtl/sbreq_msg_store.sv
module sbreq_msg_store #(
  parameter int DEPTH = 255
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we,
  input  logic [$clog2(DEPTH+1)-1:0]    waddr,
  input  logic [7:0]                    wdata,
  input  logic [$clog2(DEPTH+1)-1:0]    raddr,
  output logic [7:0]                    rdata,
  output logic [7:0]                    head0,
  output logic [7:0]                    head1,
  output logic [7:0]                    head2
);
  localparam int AW = $clog2(DEPTH + 1);

  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  assign rdata = (raddr < AW'(DEPTH)) ? mem_q[raddr] : 8'd0;
  assign head0 = mem_q[0];
  assign head1 = mem_q[1];
  assign head2 = mem_q[2];

  assert_waddr_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> waddr < AW'(DEPTH));
endmodule

// File: rtl/sbreq_cap_reply.sv
module sbreq_cap_reply
  import sbreq_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             load,
  input  logic [LEN_W-1:0] req_len,
  input  logic [7:0]       req_b2,
  input  logic [2:0]       rd_addr,
  output logic [2:0]       rsp_len,
  output logic [7:0]       rsp_data
);
  logic [2:0] len_q, len_d;
  logic [7:0] cc_q, cc_d;

  always_comb begin
    len_d = len_q;
    cc_d  = cc_q;
    if (load) begin
      if (req_len < LEN_W'(3)) begin
        cc_d  = CC_BAD_LEN;
        len_d = 3'd3;
      end else if (req_b2[3:0] != 4'd0) begin
        cc_d  = CC_BAD_FIELD;
        len_d = 3'd3;
      end else begin
        cc_d  = CC_GOOD;
        len_d = 3'd7;
      end
    end else if (clear) begin
      len_d = 3'd0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= 3'd0;
      cc_q  <= 8'd0;
    end else begin
      len_q <= len_d;
      cc_q  <= cc_d;
    end
  end

  always_comb begin
    rsp_data = 8'd0;
    if (rd_addr < len_q) begin
      unique case (rd_addr)
        3'd0:    rsp_data = CAPR_NETFN;
        3'd1:    rsp_data = CAP_OPCODE;
        3'd2:    rsp_data = cc_q;
        3'd3:    rsp_data = 8'h00;
        3'd4:    rsp_data = 8'h80;
        default: rsp_data = 8'hFF;
      endcase
    end
  end

  assign rsp_len = len_q;

  assert_rsp_len_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_len == 3'd0) || (rsp_len == 3'd3) || (rsp_len == 3'd7));
endmodule

// File: rtl/sbreq_assembler.sv
module sbreq_assembler
  import sbreq_pkg::*;
#(
  parameter int MSG_MAX   = 255,
  parameter int CHUNK_MAX = 32,
  parameter int TAG_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  input  logic [7:0]       wr_data,
  input  logic             wr_last,
  output logic             wr_reject,
  output logic             req_valid,
  input  logic             req_ready,
  output logic [7:0]       req_data,
  output logic             req_last,
  output logic [TAG_W-1:0] req_tag,
  output logic [2:0]       rsp_len,
  input  logic [2:0]       rsp_addr,
  output logic [7:0]       rsp_data
);
  localparam int LW = $clog2(MSG_MAX + 1);
  localparam int SW = LW + 1;
  localparam int CW = $clog2(CHUNK_MAX + 2);
  localparam int IW = $clog2(CHUNK_MAX);

  asm_state_e       state_q, state_d;
  logic [LW-1:0]    msg_len_q, msg_len_d;
  logic [LW-1:0]    base_q, base_d;
  logic [SW-1:0]    new_len_q, new_len_d;
  logic [CW-1:0]    n_q, n_d;
  logic [CW-1:0]    copy_q, copy_d;
  logic             cmpl_q, cmpl_d;
  logic [LW-1:0]    rd_q, rd_d;
  logic [TAG_W-1:0] tag_q, tag_d;
  logic             rej_q, rej_d;

  logic             chk_valid, chk_ok, chk_dropped;
  logic [7:0]       chk_cmd;
  logic [CW-1:0]    chk_len;
  logic [7:0]       stage_byte;
  logic             st_we;
  logic [LW-1:0]    st_waddr;
  logic [7:0]       st_rdata, head0, head1, head2;
  logic             rsp_clear, rsp_load;
  logic [SW-1:0]    append_len;

  sbreq_chunk_rx #(.CHUNK_MAX(CHUNK_MAX)) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (wr_valid),
    .in_data    (wr_data),
    .in_last    (wr_last),
    .hold       (state_q != ST_IDLE),
    .stage_idx  (copy_q[IW-1:0]),
    .stage_byte (stage_byte),
    .chk_valid  (chk_valid),
    .chk_cmd    (chk_cmd),
    .chk_len    (chk_len),
    .chk_ok     (chk_ok),
    .chk_dropped(chk_dropped)
  );

  sbreq_msg_store #(.DEPTH(MSG_MAX)) u_store (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (st_we),
    .waddr(st_waddr),
    .wdata(stage_byte),
    .raddr(rd_q),
    .rdata(st_rdata),
    .head0(head0),
    .head1(head1),
    .head2(head2)
  );

  sbreq_cap_reply #(.LEN_W(LW)) u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (rsp_clear),
    .load    (rsp_load),
    .req_len (new_len_q[LW-1:0]),
    .req_b2  (head2),
    .rd_addr (rsp_addr),
    .rsp_len (rsp_len),
    .rsp_data(rsp_data)
  );

  assign append_len = SW'(msg_len_q) + SW'(chk_len);
  assign st_waddr   = base_q + LW'(copy_q);

  always_comb begin
    state_d   = state_q;
    msg_len_d = msg_len_q;
    base_d    = base_q;
    new_len_d = new_len_q;
    n_d       = n_q;
    copy_d    = copy_q;
    cmpl_d    = cmpl_q;
    rd_d      = rd_q;
    tag_d     = tag_q;
    rej_d     = 1'b0;
    rsp_clear = 1'b0;
    rsp_load  = 1'b0;
    st_we     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (chk_valid) begin
          if (chk_dropped || !chk_ok) begin
            rej_d = 1'b1;
          end else if (chk_cmd == CMD_SINGLE || chk_cmd == CMD_START) begin
            if (chk_len < CW'(2)) begin
              rej_d = 1'b1;
            end else begin
              base_d    = '0;
              new_len_d = SW'(chk_len);
              n_d       = chk_len;
              copy_d    = '0;
              cmpl_d    = (chk_cmd == CMD_SINGLE);
              rsp_clear = 1'b1;
              state_d   = ST_COPY;
            end
          end else if (chk_cmd == CMD_MIDDLE || chk_cmd == CMD_END) begin
            if (msg_len_q == '0) begin
              rej_d = 1'b1;
            end else if (append_len > SW'(MSG_MAX)) begin
              msg_len_d = '0;
              rej_d     = 1'b1;
            end else begin
              base_d    = msg_len_q;
              new_len_d = append_len;
              n_d       = chk_len;
              copy_d    = '0;
              cmpl_d    = (chk_cmd == CMD_END) || (chk_len < CW'(CHUNK_MAX));
              state_d   = ST_COPY;
            end
          end else begin
            rej_d = 1'b1;
          end
        end
      end
      ST_COPY: begin
        rej_d = chk_valid;
        if (copy_q == n_q) begin
          msg_len_d = new_len_q[LW-1:0];
          if (!cmpl_q) begin
            state_d = ST_IDLE;
          end else if (head0 == CAPQ_NETFN && head1 == CAP_OPCODE) begin
            rsp_load  = 1'b1;
            msg_len_d = '0;
            state_d   = ST_IDLE;
          end else begin
            rd_d    = '0;
            state_d = ST_FWD;
          end
        end else begin
          st_we  = 1'b1;
          copy_d = copy_q + 1'b1;
        end
      end
      default: begin
        rej_d = chk_valid;
        if (req_ready) begin
          if (rd_q == msg_len_q - 1'b1) begin
            msg_len_d = '0;
            tag_d     = tag_q + 1'b1;
            state_d   = ST_IDLE;
          end else begin
            rd_d = rd_q + 1'b1;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      msg_len_q <= '0;
      base_q    <= '0;
      new_len_q <= '0;
      n_q       <= '0;
      copy_q    <= '0;
      cmpl_q    <= 1'b0;
      rd_q      <= '0;
      tag_q     <= '0;
      rej_q     <= 1'b0;
    end else begin
      state_q   <= state_d;
      msg_len_q <= msg_len_d;
      base_q    <= base_d;
      new_len_q <= new_len_d;
      n_q       <= n_d;
      copy_q    <= copy_d;
      cmpl_q    <= cmpl_d;
      rd_q      <= rd_d;
      tag_q     <= tag_d;
      rej_q     <= rej_d;
    end
  end

  assign wr_reject = rej_q;
  assign req_valid = (state_q == ST_FWD);
  assign req_data  = st_rdata;
  assign req_last  = (state_q == ST_FWD) && (rd_q == msg_len_q - 1'b1);
  assign req_tag   = tag_q;

  assert_fwd_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_data) &&
    $stable(req_last) && $stable(req_tag));

  assert_tag_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_last |=> req_tag == TAG_W'($past(req_tag) + 1'b1));

  assert_copy_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_COPY |-> new_len_q <= SW'(MSG_MAX));

  assert_reject_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_reject |=> !wr_reject);
endmodule

// File: tb/sbreq_assembler_tb.sv
module sbreq_assembler_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 1'b0;
  logic [7:0] wr_data = 8'd0;
  logic       wr_last = 1'b0;
  logic       wr_reject;
  logic       req_valid;
  logic       req_ready = 1'b0;
  logic [7:0] req_data;
  logic       req_last;
  logic [7:0] req_tag;
  logic [2:0] rsp_len;
  logic [2:0] rsp_addr = 3'd0;
  logic [7:0] rsp_data;

  always #4 clk = ~clk;

  sbreq_assembler u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_last(wr_last), .wr_reject(wr_reject), .req_valid(req_valid),
    .req_ready(req_ready), .req_data(req_data), .req_last(req_last),
    .req_tag(req_tag), .rsp_len(rsp_len), .rsp_addr(rsp_addr),
    .rsp_data(rsp_data)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 1'b0;
  bit stall = 1'b0;

  int rej_cnt = 0;
  int fwd_cnt = 0;
  int cap_n = 0;
  int cap_buf [300];
  int got_buf [300];
  int got_len = 0;
  int got_tag = 0;

  int pay [40];
  int mbuf [300];
  int mlen = 0;
  int efwd [300];
  int efwd_len = 0;
  int exp_tag = 0;
  int exp_rsp_len = 0;
  int exp_cc = 0;

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    finished = 1'b1;
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (rst_n && wr_reject) rej_cnt++;
    if (rst_n && req_valid && req_ready) begin
      cap_buf[cap_n] = int'(req_data);
      cap_n++;
      if (req_last) begin
        for (int i = 0; i < cap_n; i++) got_buf[i] = cap_buf[i];
        got_len = cap_n;
        got_tag = int'(req_tag);
        cap_n = 0;
        fwd_cnt++;
      end
    end
    if (cycles > 190000 && !finished) begin
      errors++;
      $display("FAIL R6 watchdog: cycles %0d expected below %0d", cycles, 190000);
      summary();
    end
  end

  always @(negedge clk) req_ready <= stall ? 1'b0 : (($urandom % 4) != 0);

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int rsp_expect(input int a);
    if (a >= exp_rsp_len) return 0;
    case (a)
      0: return 8'h1C;
      1: return 8'h57;
      2: return exp_cc;
      3: return 8'h00;
      4: return 8'h80;
      default: return 8'hFF;
    endcase
  endfunction

  task automatic model(input int cmd, input int has_len, input int lenb, input int npay,
                       output int e_rej, output int e_fwd);
    bit cmpl = 1'b0;
    e_rej = 0;
    e_fwd = 0;
    if (!has_len || lenb != npay || lenb > 32) begin
      e_rej = 1;
    end else if (cmd == 2 || cmd == 6) begin
      if (npay < 2) e_rej = 1;
      else begin
        for (int i = 0; i < npay; i++) mbuf[i] = pay[i];
        mlen = npay;
        exp_rsp_len = 0;
        cmpl = (cmd == 2);
      end
    end else if (cmd == 7 || cmd == 8) begin
      if (mlen == 0) e_rej = 1;
      else if (mlen + npay > 255) begin
        mlen = 0;
        e_rej = 1;
      end else begin
        for (int i = 0; i < npay; i++) mbuf[mlen + i] = pay[i];
        mlen = mlen + npay;
        cmpl = (cmd == 8) || (npay < 32);
      end
    end else begin
      e_rej = 1;
    end
    if (cmpl) begin
      if (mbuf[0] == 8'h18 && mbuf[1] == 8'h57) begin
        if (mlen < 3) begin exp_rsp_len = 3; exp_cc = 8'hC7; end
        else if ((mbuf[2] & 15) != 0) begin exp_rsp_len = 3; exp_cc = 8'hCC; end
        else begin exp_rsp_len = 7; exp_cc = 0; end
      end else begin
        for (int i = 0; i < mlen; i++) efwd[i] = mbuf[i];
        efwd_len = mlen;
        e_fwd = 1;
      end
      mlen = 0;
    end
  endtask

  task automatic send(input int cmd, input int has_len, input int lenb, input int npay);
    int nb = 1 + has_len + npay;
    for (int i = 0; i < nb; i++) begin
      @(negedge clk);
      wr_valid = 1'b1;
      wr_last  = (i == nb - 1);
      if (i == 0) wr_data = 8'(cmd);
      else if (has_len && i == 1) wr_data = 8'(lenb);
      else wr_data = 8'(pay[i - 1 - has_len]);
    end
    @(negedge clk);
    wr_valid = 1'b0;
    wr_last  = 1'b0;
  endtask

  task automatic settle();
    repeat (40) @(negedge clk);
    while (req_valid) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic check_fwd(input string req);
    int bad = 0;
    chk(req, "forwarded length", got_len, efwd_len);
    for (int i = 0; i < efwd_len && i < got_len; i++) if (got_buf[i] != efwd[i]) bad++;
    chk(req, "forwarded byte mismatches", bad, 0);
    chk(req, "forwarded tag", got_tag, exp_tag);
    exp_tag = (exp_tag + 1) % 256;
  endtask

  task automatic check_rsp(input string req);
    chk(req, "rsp_len", int'(rsp_len), exp_rsp_len);
    if (exp_rsp_len != 0) begin
      for (int a = 0; a < 8; a++) begin
        @(negedge clk);
        rsp_addr = 3'(a);
        #1;
        chk(req, $sformatf("rsp byte %0d", a), int'(rsp_data), rsp_expect(a));
      end
    end
  endtask

  task automatic do_write(input int cmd, input int has_len, input int lenb, input int npay,
                          input string req);
    int r0 = rej_cnt;
    int f0 = fwd_cnt;
    int e_rej, e_fwd;
    model(cmd, has_len, lenb, npay, e_rej, e_fwd);
    send(cmd, has_len, lenb, npay);
    settle();
    chk(req, "reject pulses", rej_cnt - r0, e_rej);
    chk(req, "forwarded messages", fwd_cnt - f0, e_fwd);
    if (e_fwd != 0 && fwd_cnt != f0) check_fwd(req);
    check_rsp(req);
  endtask

  task automatic fill(input int n, input int start);
    for (int i = 0; i < n; i++) pay[i] = (start + i) & 255;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk("R12", "req_valid after reset", int'(req_valid), 0);
    chk("R12", "rsp_len after reset", int'(rsp_len), 0);
    fill(4, 8'h40);
    do_write(7, 1, 4, 4, "R3");                // middle with empty store

    fill(3, 8'h2C);
    do_write(2, 1, 3, 3, "R2");                // single-part, forwarded, tag 0
    fill(3, 8'h10);
    do_write(2, 1, 4, 3, "R1");                // length byte too large
    fill(33, 8'h10);
    do_write(2, 1, 33, 33, "R1");              // over 32 bytes
    do_write(2, 0, 0, 0, "R1");                // command byte alone
    fill(1, 8'h11);
    do_write(2, 1, 1, 1, "R2");                // too short
    fill(4, 8'h22);
    do_write(3, 1, 4, 4, "R11");               // unknown code

    // R5 three-piece message
    fill(32, 8'h00); do_write(6, 1, 32, 32, "R5");
    fill(32, 8'h20); do_write(7, 1, 32, 32, "R5");
    fill(10, 8'h40); do_write(8, 1, 10, 10, "R5");
    // R5 short middle ends the message, also with zero bytes
    fill(8, 8'h50);  do_write(6, 1, 8, 8, "R5");
    fill(5, 8'h60);  do_write(7, 1, 5, 5, "R5");
    fill(8, 8'h70);  do_write(6, 1, 8, 8, "R5");
    do_write(7, 1, 0, 0, "R5");
    // R1 rejected middle leaves the stored bytes intact
    fill(32, 8'h80); do_write(6, 1, 32, 32, "R1");
    fill(6, 8'hEE);  do_write(7, 1, 7, 6, "R1");
    fill(4, 8'hA0);  do_write(8, 1, 4, 4, "R1");

    // R4 exactly 255 bytes
    fill(31, 8'h01); do_write(6, 1, 31, 31, "R4");
    for (int k = 0; k < 7; k++) begin fill(32, 32 * k + 32); do_write(7, 1, 32, 32, "R4"); end
    do_write(8, 1, 0, 0, "R4");
    // R4 overflow discards the store
    fill(32, 8'h05); do_write(6, 1, 32, 32, "R4");
    for (int k = 0; k < 6; k++) begin fill(32, 7 * k); do_write(7, 1, 32, 32, "R4"); end
    fill(32, 8'h99); do_write(7, 1, 32, 32, "R4");
    fill(2, 8'h31);  do_write(8, 1, 2, 2, "R4");

    // R7 / R8 local capability answers
    pay[0] = 8'h18; pay[1] = 8'h57; pay[2] = 8'h00;
    do_write(2, 1, 3, 3, "R7");
    pay[2] = 8'h05;
    do_write(2, 1, 3, 3, "R8");
    do_write(2, 1, 2, 2, "R8");
    pay[0] = 8'h18; pay[1] = 8'h57; pay[2] = 8'h40;
    do_write(6, 1, 3, 3, "R10");               // start clears the answer
    do_write(8, 1, 0, 0, "R7");                // completes a good query

    // R9 write arriving while a message is stalled on the output
    begin
      int r0, e_rej, e_fwd, held;
      stall = 1'b1;
      fill(5, 8'h30);
      model(2, 1, 5, 5, e_rej, e_fwd);
      send(2, 1, 5, 5);
      repeat (40) @(negedge clk);
      chk("R9", "req_valid while stalled", int'(req_valid), 1);
      held = int'(req_data);
      r0 = rej_cnt;
      fill(4, 8'hC0);
      send(2, 1, 4, 4);
      repeat (10) @(negedge clk);
      chk("R9", "reject pulses while busy", rej_cnt - r0, 1);
      chk("R9", "stalled byte", int'(req_data), held);
      stall = 1'b0;
      settle();
      check_fwd("R9");
    end

    // random traffic
    for (int it = 0; it < 300; it++) begin
      int sel = $urandom % 10;
      int cmd, npay, lenb, has_len;
      case (sel)
        0, 1: cmd = 2;
        2, 3: cmd = 6;
        4, 5, 6: cmd = 7;
        7: cmd = 8;
        8: cmd = (($urandom % 2) != 0) ? 3 : 10;
        default: cmd = $urandom % 256;
      endcase
      case ($urandom % 4)
        0: npay = 32;
        1: npay = $urandom % 33;
        2: npay = $urandom % 4;
        default: npay = (($urandom % 3) == 0) ? 33 : 32;
      endcase
      for (int i = 0; i < npay; i++) pay[i] = $urandom % 256;
      if (npay >= 2 && ($urandom % 5) == 0) begin pay[0] = 8'h18; pay[1] = 8'h57; end
      lenb = (($urandom % 8) == 0) ? npay + 1 : npay;
      has_len = (($urandom % 20) == 0) ? 0 : 1;
      if (!has_len) npay = 0;
      do_write(cmd, has_len, lenb, npay, "R6");
    end
    summary();
  end
endmodule